// File: doc/BRIEF.md
# Keyboard Matrix Row Port

This block gives a processor a single I/O port through which it reads a keyboard matrix one row at a time. The matrix holds a parameterised number of rows, up to sixteen, each of a parameterised number of key columns (eight by default). A write to the port stores a row index. A read from the same port returns the key bits of that row, active low, so an idle row reads as all ones.

On the other side, a host interface keeps the key state. Each key event carries a code whose upper byte names the row and whose lower field is a mask of the columns it affects. A flag on the event says whether those keys go down or come up. A separate release-all strobe brings every key up at once. The block holds only the decoded port, the row index latch, the key state and the read selector. Matrix scanning and debouncing happen elsewhere.

Top module: `kbd_row_port`

## Requirements
- R1: The port responds only when `io_addr` equals 0xB5. A write at any other address leaves the row index unchanged, and a read at any other address returns all ones.
- R2: A port write stores `io_wdata[3:0]` as the row index at the next clock edge. `io_wdata[7:4]` is ignored.
- R3: A port read returns, in the same cycle, the key bits of the row named by the stored index.
- R4: When the stored row index is ROWS (default 10) or greater, a port read returns all ones.
- R5: A key event with `key_down`=1 clears, from the next cycle on, every bit of row `key_code[15:8]` that is set in `key_code[7:0]`. Other bits and other rows keep their values.
- R6: A key event with `key_down`=0 sets, from the next cycle on, every bit of row `key_code[15:8]` that is set in `key_code[7:0]`.
- R7: `release_all` sets every row to all ones at the next edge, and it wins over a key event in the same cycle.
- R8: A key event whose row field is ROWS or greater changes no row.
- R9: After reset the row index is 0 and every row reads all ones.
- R10: While `io_rd` is low, `io_rdata` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| key_valid | input | 1 | Key event strobe |
| key_down | input | 1 | 1 presses the masked keys, 0 releases them |
| key_code | input | 16 | Row in [15:8], column mask in [7:0] |
| release_all | input | 1 | Brings every key up |

## Verification
A table of port writes and key events first builds up single-bit presses, multi-bit presses and partial releases on two rows. Each is read back through the port, so a wrong row, a wrong mask polarity or an OR in place of an AND shows up as a wrong byte. A select byte with its upper nibble set tells a four-bit latch apart from a full-byte latch. Indices at and above the row count tell a guarded selector from an aliased one. Directed cases then send key events whose row field would alias onto a real row if truncated, send writes to a neighbouring address, pulse release-all together with a press, and read with the strobe low.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
   localparam int unsigned KBD_ROW_FIELD_W = 8;
   localparam int unsigned KBD_MAX_SEL_W   = 4;

   function automatic logic [KBD_ROW_FIELD_W-1:0] kbd_row_of(input int unsigned r);
      return KBD_ROW_FIELD_W'(r);
   endfunction
endpackage

// File: rtl/kbd_port_decode.sv
module kbd_port_decode #(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [7:0]  PORT_ADDR = 8'hB5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              wr_hit,
   output logic              rd_hit
);
   logic match;

   initial begin
      if (ADDR_W != 8) $error("kbd_port_decode: ADDR_W must be 8");
   end

   assign match  = (addr == PORT_ADDR);
   assign wr_hit = wr & match;
   assign rd_hit = rd & match;
endmodule

// File: rtl/kbd_row_latch.sv
module kbd_row_latch #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   output logic [SEL_W-1:0]  sel_q
);
   initial begin
      if (SEL_W > DATA_W) $error("kbd_row_latch: SEL_W wider than DATA_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    sel_q <= '0;
      else if (load) sel_q <= wdata[SEL_W-1:0];
   end
endmodule

// File: rtl/kbd_key_store.sv
module kbd_key_store
   import kbd_pkg::*;
#(
   parameter int unsigned ROWS = 10,
   parameter int unsigned COLS = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ev_valid,
   input  logic                             ev_down,
   input  logic [KBD_ROW_FIELD_W-1:0]       ev_row,
   input  logic [COLS-1:0]                  ev_mask,
   input  logic                             clear_all,
   output logic [ROWS*COLS-1:0]             rows_flat
);
   initial begin
      if (ROWS < 1)  $error("kbd_key_store: ROWS must be at least 1");
      if (COLS < 1)  $error("kbd_key_store: COLS must be at least 1");
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] row_q;
      logic            hit;

      assign hit = ev_valid && (ev_row == kbd_row_of(r));

      always_ff @(posedge clk) begin
         if (!rst_n)         row_q <= '1;
         else if (clear_all) row_q <= '1;
         else if (hit) begin
            if (ev_down) row_q <= row_q & ~ev_mask;
            else         row_q <= row_q |  ev_mask;
         end
      end

      assign rows_flat[r*COLS +: COLS] = row_q;
   end
endmodule

// File: rtl/kbd_row_mux.sv
module kbd_row_mux #(
   parameter int unsigned ROWS  = 10,
   parameter int unsigned COLS  = 8,
   parameter int unsigned SEL_W = 4
) (
   input  logic [ROWS*COLS-1:0] rows_flat,
   input  logic [SEL_W-1:0]     sel,
   input  logic                 enable,
   output logic [COLS-1:0]      dout
);
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   logic [COLS-1:0] picked;

   initial begin
      if (ROWS > SEL_SPAN) $error("kbd_row_mux: ROWS exceeds the selector range");
   end

   if (ROWS == SEL_SPAN) begin : g_full
      always_comb begin
         picked = rows_flat[sel*COLS +: COLS];
      end
   end else begin : g_partial
      always_comb begin
         picked = '1;
         for (int r = 0; r < ROWS; r++) begin
            if (sel == SEL_W'(r)) picked = rows_flat[r*COLS +: COLS];
         end
      end
   end

   assign dout = enable ? picked : '1;
endmodule

// File: rtl/kbd_row_port.sv
module kbd_row_port
   import kbd_pkg::*;
#(
   parameter int unsigned ROWS      = 10,
   parameter int unsigned COLS      = 8,
   parameter int unsigned SEL_W     = 4,
   parameter logic [7:0]  PORT_ADDR = 8'hB5,
   localparam int unsigned CODE_W   = KBD_ROW_FIELD_W + COLS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [COLS-1:0]   io_rdata,
   input  logic              key_valid,
   input  logic              key_down,
   input  logic [CODE_W-1:0] key_code,
   input  logic              release_all
);
   logic                 wr_hit;
   logic                 rd_hit;
   logic [SEL_W-1:0]     sel_q;
   logic [ROWS*COLS-1:0] rows_flat;

   initial begin
      if (SEL_W > KBD_MAX_SEL_W) $error("kbd_row_port: SEL_W above 4");
      if (ROWS > (1 << SEL_W))   $error("kbd_row_port: ROWS above selector range");
      if (COLS != 8)             $error("kbd_row_port: COLS must match the data byte");
   end

   kbd_port_decode #(.ADDR_W(8), .PORT_ADDR(PORT_ADDR)) u_dec (
      .addr   (io_addr),
      .wr     (io_wr),
      .rd     (io_rd),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   kbd_row_latch #(.DATA_W(8), .SEL_W(SEL_W)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_hit),
      .wdata (io_wdata),
      .sel_q (sel_q)
   );

   kbd_key_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (key_valid),
      .ev_down   (key_down),
      .ev_row    (key_code[CODE_W-1 -: KBD_ROW_FIELD_W]),
      .ev_mask   (key_code[COLS-1:0]),
      .clear_all (release_all),
      .rows_flat (rows_flat)
   );

   kbd_row_mux #(.ROWS(ROWS), .COLS(COLS), .SEL_W(SEL_W)) u_mux (
      .rows_flat (rows_flat),
      .sel       (sel_q),
      .enable    (rd_hit),
      .dout      (io_rdata)
   );
endmodule

// File: rtl/kbd_row_port_chk.sv
module kbd_row_port_chk #(
   parameter int unsigned ROWS  = 10,
   parameter int unsigned COLS  = 8,
   parameter int unsigned SEL_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [7:0]           io_addr,
   input logic                 io_wr,
   input logic                 io_rd,
   input logic [7:0]           io_wdata,
   input logic [COLS-1:0]      io_rdata,
   input logic                 key_valid,
   input logic                 key_down,
   input logic [15:0]          key_code,
   input logic                 release_all,
   input logic [SEL_W-1:0]     sel_q,
   input logic [ROWS*COLS-1:0] rows_flat
);
   logic            ev_q;
   logic            ev_down_q;
   logic [7:0]      ev_row_q;
   logic [COLS-1:0] ev_mask_q;
   logic [COLS-1:0] ev_row_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_q      <= 1'b0;
         ev_down_q <= 1'b0;
         ev_row_q  <= '0;
         ev_mask_q <= '0;
      end else begin
         ev_q      <= key_valid && !release_all && (int'(key_code[15:8]) < ROWS);
         ev_down_q <= key_down;
         ev_row_q  <= key_code[15:8];
         ev_mask_q <= key_code[COLS-1:0];
      end
   end

   always_comb begin
      ev_row_bits = '1;
      for (int r = 0; r < ROWS; r++) begin
         if (ev_row_q == 8'(r)) ev_row_bits = rows_flat[r*COLS +: COLS];
      end
   end

   // R2
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 8'hB5) |=> (sel_q == $past(io_wdata[SEL_W-1:0])));

   // R1
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == 8'hB5) |=> $stable(sel_q));

   // R4
   out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == 8'hB5 && int'(sel_q) >= ROWS) |-> (io_rdata == '1));

   // R10
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == '1));

   // R7
   release_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_all |=> (rows_flat == '1));

   // R5
   press_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q && ev_down_q) |-> ((ev_row_bits & ev_mask_q) == '0));

   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q && !ev_down_q) |-> ((ev_row_bits & ev_mask_q) == ev_mask_q));

   // R8
   ignore_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && !release_all && int'(key_code[15:8]) >= ROWS) |=> $stable(rows_flat));

   // R9
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (sel_q == '0 && rows_flat == '1));
endmodule

bind kbd_row_port kbd_row_port_chk #(.ROWS(ROWS), .COLS(COLS), .SEL_W(SEL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_addr     (io_addr),
   .io_wr       (io_wr),
   .io_rd       (io_rd),
   .io_wdata    (io_wdata),
   .io_rdata    (io_rdata),
   .key_valid   (key_valid),
   .key_down    (key_down),
   .key_code    (key_code),
   .release_all (release_all),
   .sel_q       (sel_q),
   .rows_flat   (rows_flat)
);

// File: tb/kbd_row_port_tb.sv
`timescale 1ns/1ps
module kbd_row_port_tb;
   localparam logic [1:0] OP_PRESS = 2'd0;
   localparam logic [1:0] OP_REL   = 2'd1;
   localparam logic [1:0] OP_SEL   = 2'd2;
   localparam logic [1:0] OP_READ  = 2'd3;
   localparam int NVEC = 20;

   localparam logic [25:0] VEC [NVEC] = '{
      {OP_SEL,   16'h0003, 8'h00},
      {OP_READ,  16'h0000, 8'hFF},
      {OP_PRESS, 16'h0301, 8'h00},
      {OP_READ,  16'h0000, 8'hFE},
      {OP_PRESS, 16'h0380, 8'h00},
      {OP_READ,  16'h0000, 8'h7E},
      {OP_REL,   16'h0301, 8'h00},
      {OP_READ,  16'h0000, 8'h7F},
      {OP_PRESS, 16'h09F0, 8'h00},
      {OP_SEL,   16'h0009, 8'h00},
      {OP_READ,  16'h0000, 8'h0F},
      {OP_SEL,   16'h00F9, 8'h00},
      {OP_READ,  16'h0000, 8'h0F},
      {OP_SEL,   16'h0003, 8'h00},
      {OP_READ,  16'h0000, 8'h7F},
      {OP_SEL,   16'h000A, 8'h00},
      {OP_READ,  16'h0000, 8'hFF},
      {OP_PRESS, 16'h0A01, 8'h00},
      {OP_SEL,   16'h000F, 8'h00},
      {OP_READ,  16'h0000, 8'hFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = 8'h00;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        key_valid = 1'b0;
   logic        key_down = 1'b0;
   logic [15:0] key_code = 16'h0000;
   logic        release_all = 1'b0;

   int  n_tests = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic [7:0] rv;

   always #4 clk = ~clk;

   kbd_row_port u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .key_valid(key_valid),
      .key_down(key_down), .key_code(key_code), .release_all(release_all)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic port_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic port_read(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 v = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic key_event(input logic down, input logic [15:0] code);
      @(negedge clk);
      key_valid = 1'b1; key_down = down; key_code = code;
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: index 0 after reset, shown by a press on row 0 seen without any select write
      port_read(8'hB5, rv);
      check("R9 row0 idle", rv, 8'hFF);
      key_event(1'b1, 16'h0001);
      port_read(8'hB5, rv);
      check("R9 index zero", rv, 8'hFE);
      key_event(1'b0, 16'h0001);
      for (int r = 1; r < 16; r++) begin
         port_write(8'hB5, 8'(r));
         port_read(8'hB5, rv);
         check("R9 rows idle", rv, 8'hFF);
      end

      // R3, R5, R6, R2, R4: table walk
      for (int i = 0; i < NVEC; i++) begin
         case (VEC[i][25:24])
            OP_PRESS: key_event(1'b1, VEC[i][23:8]);
            OP_REL:   key_event(1'b0, VEC[i][23:8]);
            OP_SEL:   port_write(8'hB5, VEC[i][15:8]);
            default: begin
               port_read(8'hB5, rv);
               check("R3 table read", rv, VEC[i][7:0]);
            end
         endcase
      end

      // R8: rows out of range ignored, including one aliasing to row 3 if truncated
      key_event(1'b1, 16'h1302);
      key_event(1'b1, 16'h0C01);
      port_write(8'hB5, 8'h03);
      port_read(8'hB5, rv);
      check("R8 row3 untouched", rv, 8'h7F);
      port_write(8'hB5, 8'h09);
      port_read(8'hB5, rv);
      check("R8 row9 untouched", rv, 8'h0F);

      // R4: index exactly ROWS
      port_write(8'hB5, 8'h0A);
      port_read(8'hB5, rv);
      check("R4 index 10", rv, 8'hFF);

      // R1: neighbouring addresses
      port_write(8'hB5, 8'h03);
      port_write(8'hB4, 8'h09);
      port_read(8'hB5, rv);
      check("R1 write elsewhere", rv, 8'h7F);
      port_read(8'hB6, rv);
      check("R1 read elsewhere", rv, 8'hFF);

      // R2: upper nibble ignored
      port_write(8'hB5, 8'hA9);
      port_read(8'hB5, rv);
      check("R2 upper nibble", rv, 8'h0F);

      // R5, R6 on row 0
      port_write(8'hB5, 8'h00);
      key_event(1'b1, 16'h0004);
      port_read(8'hB5, rv);
      check("R5 press row0", rv, 8'hFB);

      // R10: strobe low
      @(negedge clk);
      io_addr = 8'hB5; io_rd = 1'b0;
      #1 check("R10 strobe low", io_rdata, 8'hFF);

      key_event(1'b0, 16'h0004);
      port_read(8'hB5, rv);
      check("R6 release row0", rv, 8'hFF);

      // R7: release-all wins over a press in the same cycle
      key_event(1'b1, 16'h0010);
      @(negedge clk);
      release_all = 1'b1; key_valid = 1'b1; key_down = 1'b1; key_code = 16'h0001;
      @(negedge clk);
      release_all = 1'b0; key_valid = 1'b0;
      for (int r = 0; r < 16; r++) begin
         port_write(8'hB5, 8'(r));
         port_read(8'hB5, rv);
         check("R7 all up", rv, 8'hFF);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule